// File: doc/BRIEF.md
# DRAM Row Boundary Decoder

This block decides which of eight DRAM rows a physical address falls in. Each row is described by a single cumulative upper limit, in megabytes, measured from address zero. The lower limit of a row is the upper limit of the row before it. Row 0 starts at zero. Software builds each limit from two pieces. An 8-bit low byte is held per row. A 4-bit high nibble is taken from a shared 32-bit extension word. A row that is not populated repeats the limit of the row before it, so its size is zero.

A lookup presents a 32-bit address with a valid strobe. Only address bits 29:20, the address in megabytes, take part in the compare. One clock later the block returns the selected row index and a hit flag. The block also drives a top-of-memory figure. It is the highest row limit plus an optional memory gap size, and it never exceeds 512 MB. The gap affects only this figure. The row limits describe DRAM alone.

Top module: `dram_row_decoder`

## Requirements
- R1: The limit of row n is the 12-bit value {extension[4n+3:4n], low byte n}, in MB. Write address n (0 to 7) loads low byte n. Write address 8+k (k = 0 to 3) loads extension bits 8k+7:8k.
- R2: Only lk_addr[29:20] is compared, zero-extended to 12 bits. Bits 31:30 and 19:0 have no effect on the result.
- R3: On a hit, row_idx is the lowest n with address_MB < limit n. Row 0 covers addresses from 0 MB.
- R4: A row whose limit equals the previous row's limit (for row 0, a limit of zero) is never selected.
- R5: An address at or above the row 7 limit gives row_hit = 0 and row_idx = 0. This holds when the limits are programmed non-decreasing.
- R6: row_valid, row_hit and row_idx are registered, one cycle after lk_valid. In a cycle that follows no lookup, all three are 0.
- R7: tom_mb equals the row 7 limit, plus gap_mb when gap_en = 1. It updates combinationally with no clock delay.
- R8: When that sum exceeds 512, tom_mb is 512.
- R9: After reset every limit is zero. Every lookup then misses, and tom_mb equals the gap term alone.
- R10: A write to addresses 12 to 15 changes no limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register byte address |
| wr_data | input | 8 | Register write data |
| gap_en | input | 1 | Add the memory gap to top of memory |
| gap_mb | input | 10 | Memory gap size in MB |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup physical address |
| row_valid | output | 1 | Lookup result valid |
| row_hit | output | 1 | Address falls inside populated DRAM |
| row_idx | output | 3 | Selected row |
| tom_mb | output | 10 | Top of memory in MB, capped at 512 |

## Verification
The bench probes the address just below and exactly at each row limit. An off-by-one comparator (<= instead of <) would report the wrong row at every boundary. It also looks up addresses that land on zero-size rows. A priority encoder that picks the highest matching row, instead of the lowest, would return the empty row instead of the next populated one. The mixed configuration places nibble bits in the upper extension byte. A misplaced nibble slice would cap that layout at 32 MB instead of 288 MB. Gap sums are driven past 512 MB to catch a missing clamp, and unused address bits are set to catch a compare on the wrong bit slice.

// File: rtl/drb_pkg.sv
package drb_pkg;
  localparam int DRB_ROWS   = 8;
  localparam int DRB_BYTE_W = 8;
  localparam int DRB_NIB_W  = 4;
  localparam int DRB_MB_W   = 10;
  localparam int DRB_MB_LSB = 20;
  localparam int DRB_GAP_W  = 10;
  localparam int DRB_CAP_MB = 512;
  localparam int DRB_BND_W  = DRB_BYTE_W + DRB_NIB_W;
  localparam int DRB_TOM_W  = $clog2(DRB_CAP_MB + 1);
endpackage

// File: rtl/drb_regfile.sv
module drb_regfile #(
  parameter int ROWS   = drb_pkg::DRB_ROWS,
  parameter int BYTE_W = drb_pkg::DRB_BYTE_W,
  parameter int NIB_W  = drb_pkg::DRB_NIB_W,
  parameter int WA_W   = 4,
  localparam int BND_W  = BYTE_W + NIB_W,
  localparam int EXT_W  = ROWS * NIB_W,
  localparam int EXT_BY = EXT_W / BYTE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [WA_W-1:0]       wr_addr,
  input  logic [BYTE_W-1:0]     wr_data,
  output logic [ROWS*BND_W-1:0] bnd_flat,
  output logic                  wr_unmapped
);
  logic [BYTE_W-1:0] lo_q [ROWS];
  logic [EXT_W-1:0]  ext_q;

  function automatic logic [BND_W-1:0] join_limit(logic [NIB_W-1:0] hi,
                                                  logic [BYTE_W-1:0] lo);
    return {hi, lo};
  endfunction

  assign wr_unmapped = wr_en && (32'(wr_addr) >= 32'(ROWS + EXT_BY));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) lo_q[r] <= '0;
      ext_q <= '0;
    end else if (wr_en) begin
      for (int r = 0; r < ROWS; r++)
        if (32'(wr_addr) == r) lo_q[r] <= wr_data;
      for (int e = 0; e < EXT_BY; e++)
        if (32'(wr_addr) == ROWS + e) ext_q[e*BYTE_W +: BYTE_W] <= wr_data;
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_limit
    assign bnd_flat[r*BND_W +: BND_W] = join_limit(ext_q[r*NIB_W +: NIB_W], lo_q[r]);
  end
endmodule

// File: rtl/drb_row_lookup.sv
module drb_row_lookup #(
  parameter int ROWS  = drb_pkg::DRB_ROWS,
  parameter int BND_W = drb_pkg::DRB_BND_W,
  parameter int MB_W  = drb_pkg::DRB_MB_W,
  localparam int IDX_W = $clog2(ROWS)
) (
  input  logic [MB_W-1:0]       addr_mb,
  input  logic [ROWS*BND_W-1:0] bnd_flat,
  output logic [ROWS-1:0]       below_vec,
  output logic                  hit,
  output logic [IDX_W-1:0]      idx
);
  logic [BND_W-1:0] addr_ext;
  assign addr_ext = {{(BND_W-MB_W){1'b0}}, addr_mb};

  for (genvar r = 0; r < ROWS; r++) begin : g_cmp
    assign below_vec[r] = addr_ext < bnd_flat[r*BND_W +: BND_W];
  end

  function automatic logic [IDX_W-1:0] first_set(logic [ROWS-1:0] v);
    logic [IDX_W-1:0] k;
    k = '0;
    for (int r = ROWS - 1; r >= 0; r--)
      if (v[r]) k = IDX_W'(r);
    return k;
  endfunction

  assign hit = |below_vec;
  assign idx = hit ? first_set(below_vec) : '0;
endmodule

// File: rtl/drb_tom_calc.sv
module drb_tom_calc #(
  parameter int BND_W  = drb_pkg::DRB_BND_W,
  parameter int GAP_W  = drb_pkg::DRB_GAP_W,
  parameter int CAP_MB = drb_pkg::DRB_CAP_MB,
  localparam int TOM_W = $clog2(CAP_MB + 1),
  localparam int SUM_W = BND_W + 1
) (
  input  logic [BND_W-1:0] top_bnd,
  input  logic             gap_en,
  input  logic [GAP_W-1:0] gap_mb,
  output logic [TOM_W-1:0] tom_mb,
  output logic             tom_clamped
);
  function automatic logic [SUM_W-1:0] raw_top(logic [BND_W-1:0] t,
                                               logic en, logic [GAP_W-1:0] g);
    logic [SUM_W-1:0] gt;
    gt = en ? {{(SUM_W-GAP_W){1'b0}}, g} : '0;
    return {1'b0, t} + gt;
  endfunction

  logic [SUM_W-1:0] sum;
  assign sum         = raw_top(top_bnd, gap_en, gap_mb);
  assign tom_clamped = sum > SUM_W'(CAP_MB);
  assign tom_mb      = tom_clamped ? TOM_W'(CAP_MB) : sum[TOM_W-1:0];
endmodule

// File: rtl/dram_row_decoder.sv
module dram_row_decoder #(
  parameter int ROWS   = drb_pkg::DRB_ROWS,
  parameter int BYTE_W = drb_pkg::DRB_BYTE_W,
  parameter int NIB_W  = drb_pkg::DRB_NIB_W,
  parameter int MB_W   = drb_pkg::DRB_MB_W,
  parameter int MB_LSB = drb_pkg::DRB_MB_LSB,
  parameter int GAP_W  = drb_pkg::DRB_GAP_W,
  parameter int CAP_MB = drb_pkg::DRB_CAP_MB,
  parameter int ADDR_W = 32,
  localparam int BND_W = BYTE_W + NIB_W,
  localparam int WA_W  = $clog2(ROWS + (ROWS*NIB_W)/BYTE_W),
  localparam int IDX_W = $clog2(ROWS),
  localparam int TOM_W = $clog2(CAP_MB + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WA_W-1:0]   wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              gap_en,
  input  logic [GAP_W-1:0]  gap_mb,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              row_valid,
  output logic              row_hit,
  output logic [IDX_W-1:0]  row_idx,
  output logic [TOM_W-1:0]  tom_mb
);
  logic [ROWS*BND_W-1:0] bnd_flat;
  logic                  wr_unmapped;
  logic [MB_W-1:0]       addr_mb;
  logic [ROWS-1:0]       below_vec;
  logic                  hit_comb;
  logic [IDX_W-1:0]      idx_comb;
  logic                  tom_clamped;
  logic [BND_W-1:0]      top_bnd;
  logic                  unused_addr_bits;

  assign addr_mb          = lk_addr[MB_LSB +: MB_W];
  assign unused_addr_bits = ^{lk_addr[ADDR_W-1:MB_LSB+MB_W], lk_addr[MB_LSB-1:0]};
  assign top_bnd          = bnd_flat[(ROWS-1)*BND_W +: BND_W];

  drb_regfile #(.ROWS(ROWS), .BYTE_W(BYTE_W), .NIB_W(NIB_W), .WA_W(WA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .bnd_flat(bnd_flat), .wr_unmapped(wr_unmapped));

  drb_row_lookup #(.ROWS(ROWS), .BND_W(BND_W), .MB_W(MB_W)) u_look (
    .addr_mb(addr_mb), .bnd_flat(bnd_flat), .below_vec(below_vec),
    .hit(hit_comb), .idx(idx_comb));

  drb_tom_calc #(.BND_W(BND_W), .GAP_W(GAP_W), .CAP_MB(CAP_MB)) u_tom (
    .top_bnd(top_bnd), .gap_en(gap_en), .gap_mb(gap_mb),
    .tom_mb(tom_mb), .tom_clamped(tom_clamped));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_valid <= 1'b0;
      row_hit   <= 1'b0;
      row_idx   <= '0;
    end else begin
      row_valid <= lk_valid;
      row_hit   <= lk_valid && hit_comb;
      row_idx   <= lk_valid ? idx_comb : '0;
    end
  end
endmodule

// File: rtl/drb_checker.sv
module drb_checker #(
  parameter int ROWS   = 8,
  parameter int BND_W  = 12,
  parameter int MB_W   = 10,
  parameter int CAP_MB = 512,
  parameter int WA_W   = 4,
  localparam int IDX_W = $clog2(ROWS),
  localparam int TOM_W = $clog2(CAP_MB + 1)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic                  gap_en,
  input logic                  lk_valid,
  input logic [MB_W-1:0]       addr_mb,
  input logic [ROWS*BND_W-1:0] bnd_flat,
  input logic                  wr_unmapped,
  input logic                  row_valid,
  input logic                  row_hit,
  input logic [IDX_W-1:0]      row_idx,
  input logic [TOM_W-1:0]      tom_mb,
  input logic [BND_W-1:0]      top_bnd
);
  logic [BND_W-1:0] sel_hi, sel_lo, prev_addr;

  always_comb begin
    sel_hi = '0;
    sel_lo = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (32'(row_idx) == r) begin
        sel_hi = bnd_flat[r*BND_W +: BND_W];
        if (r > 0) sel_lo = bnd_flat[(r-1)*BND_W +: BND_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_addr <= '0;
    else        prev_addr <= {{(BND_W-MB_W){1'b0}}, addr_mb};

  // R6: result follows the request by one clock
  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    row_valid == $past(lk_valid));

  // R6: no stale result without a request
  p_idle_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !row_valid |-> (!row_hit && row_idx == '0));

  // R5: a miss always reports row 0
  p_miss_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid && !row_hit) |-> row_idx == '0);

  // R3: the looked-up address lies inside the reported row's range
  p_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (row_hit && $past(!wr_en)) |-> (prev_addr < sel_hi && prev_addr >= sel_lo));

  // R4: a selected row always has nonzero size
  p_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (row_hit && $past(!wr_en)) |-> sel_hi > sel_lo);

  // R8: top of memory never passes the cap
  p_tom_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    32'(tom_mb) <= CAP_MB);

  // R7: without the gap, top of memory tracks the highest row limit
  p_tom_nogap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!gap_en && 32'(top_bnd) <= CAP_MB) |-> 32'(tom_mb) == 32'(top_bnd));

  // R10: unmapped writes leave every limit untouched
  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_unmapped |=> $stable(bnd_flat));
endmodule

bind dram_row_decoder drb_checker #(
  .ROWS(ROWS), .BND_W(BND_W), .MB_W(MB_W), .CAP_MB(CAP_MB), .WA_W(WA_W)
) u_drb_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .gap_en(gap_en),
  .lk_valid(lk_valid), .addr_mb(addr_mb), .bnd_flat(bnd_flat),
  .wr_unmapped(wr_unmapped), .row_valid(row_valid), .row_hit(row_hit),
  .row_idx(row_idx), .tom_mb(tom_mb), .top_bnd(top_bnd));

// File: tb/dram_row_decoder_tb_top.sv
`timescale 1ns/1ps
module dram_row_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        gap_en = 1'b0;
  logic [9:0]  gap_mb = '0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        row_valid, row_hit;
  logic [2:0]  row_idx;
  logic [9:0]  tom_mb;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dram_row_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .gap_en(gap_en), .gap_mb(gap_mb),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .row_valid(row_valid),
    .row_hit(row_hit), .row_idx(row_idx), .tom_mb(tom_mb));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Result registered at the posedge between the two negedges.
  task automatic look(input logic [31:0] a, input bit eh, input int ei, input string req);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    chk({req, " valid"}, int'(row_valid), 1);
    chk({req, " hit"}, int'(row_hit), int'(eh));
    chk({req, " idx"}, int'(row_idx), ei);
  endtask

  function automatic logic [31:0] mb(input int m);
    return 32'(m) << 20;
  endfunction

  task automatic t_reset;
    chk("R9 reset valid", int'(row_valid), 0);
    chk("R9 reset tom", int'(tom_mb), 0);
    look(mb(0), 0, 0, "R9 empty at 0");
    look(mb(300), 0, 0, "R9 empty at 300");
    @(negedge clk); gap_en = 1'b1; gap_mb = 10'd64; #1;
    chk("R9 gap only tom", int'(tom_mb), 64);
    gap_en = 1'b0; gap_mb = '0;
  endtask

  task automatic t_single;
    wr(4'd0, 8'h02); wr(4'd1, 8'h02); wr(4'd2, 8'h04); wr(4'd3, 8'h04);
    wr(4'd4, 8'h06); wr(4'd5, 8'h06); wr(4'd6, 8'h08); wr(4'd7, 8'h08);
    for (int k = 8; k < 12; k++) wr(4'(k), 8'h00);
    #1 chk("R7 tom single", int'(tom_mb), 8);
    look(mb(0), 1, 0, "R3 mb0");
    look(mb(1) | 32'hFFFFF, 1, 0, "R2 mb1 low bits");
    look(mb(2), 1, 2, "R4 skip row1");
    look(mb(3), 1, 2, "R3 mb3");
    look(mb(4), 1, 4, "R4 skip row3");
    look(mb(5), 1, 4, "R3 mb5");
    look(mb(6), 1, 6, "R4 skip row5");
    look(mb(7), 1, 6, "R3 mb7");
    look(mb(8), 0, 0, "R5 at top");
    look(mb(9), 0, 0, "R5 above top");
  endtask

  task automatic t_mixed;
    wr(4'd0, 8'h08); wr(4'd1, 8'h10); wr(4'd2, 8'h18); wr(4'd3, 8'h20);
    wr(4'd4, 8'hA0); wr(4'd5, 8'hA0); wr(4'd6, 8'h20); wr(4'd7, 8'h20);
    wr(4'd11, 8'h11);
    #1 chk("R1 tom mixed", int'(tom_mb), 288);
    look(mb(7), 1, 0, "R3 mb7");
    look(mb(8), 1, 1, "R3 mb8");
    look(mb(15), 1, 1, "R3 mb15");
    look(mb(16), 1, 2, "R3 mb16");
    look(mb(24), 1, 3, "R3 mb24");
    look(mb(31), 1, 3, "R3 mb31");
    look(mb(32), 1, 4, "R3 mb32");
    look(mb(40) | 32'hC000_0000, 1, 4, "R2 high bits ignored");
    look(mb(159), 1, 4, "R3 mb159");
    look(mb(160), 1, 6, "R4 skip row5");
    look(mb(287), 1, 6, "R1 nibble row6");
    look(mb(288), 0, 0, "R5 at 288");
    look(mb(1023), 0, 0, "R5 mb1023");
  endtask

  task automatic t_gap;
    @(negedge clk); gap_en = 1'b1; gap_mb = 10'd128; #1;
    chk("R7 tom plus gap", int'(tom_mb), 416);
    gap_mb = 10'd224; #1;
    chk("R8 tom exact cap", int'(tom_mb), 512);
    gap_mb = 10'd256; #1;
    chk("R8 tom clamped", int'(tom_mb), 512);
    gap_en = 1'b0; #1;
    chk("R7 gap disabled", int'(tom_mb), 288);
    look(mb(300), 0, 0, "R7 gap not in rows");
  endtask

  task automatic t_unmapped;
    for (int k = 12; k < 16; k++) wr(4'(k), 8'hFF);
    #1 chk("R10 tom unchanged", int'(tom_mb), 288);
    look(mb(288), 0, 0, "R10 top unchanged");
    look(mb(0), 1, 0, "R10 row0 unchanged");
    look(mb(160), 1, 6, "R10 row5 still empty");
  endtask

  task automatic t_idle;
    look(mb(20), 1, 2, "R6 lookup");
    @(negedge clk);
    chk("R6 idle valid", int'(row_valid), 0);
    chk("R6 idle hit", int'(row_hit), 0);
    chk("R6 idle idx", int'(row_idx), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_mixed();
    t_gap();
    t_unmapped();
    t_idle();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule